// File: doc/BRIEF.md
# Seconds Alarm Comparator with Latched Flag

This block sits beside a free-running seconds counter in a real-time clock and watches it for one programmed instant. Software stores a target second in a 32-bit alarm register. Each time the counter advances, the block compares the new count with that target. On a match it latches a flag that stays set until software reloads the alarm register.

The flag always records a match; it cannot be masked. A separate enable input gates only the interrupt output, which is registered and follows the flag. The block tests for a match only when the counter advances. Loading a target below the present count therefore disarms it, because the counter never returns to that value before it wraps. The counter, its prescaler and any bus decoding live outside the block.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous active-high reset, the alarm register, the flag and the interrupt output all read zero.
- R2: A write strobe loads the write data into the alarm register, and `alarm_o` shows the new value from the next clock cycle on.
- R3: When the increment pulse is high and the seconds input equals the stored alarm value in that same cycle, the flag reads one from the next cycle on. This includes the all-ones value.
- R4: With no increment pulse, the flag does not set even when the seconds input equals the alarm value.
- R5: An increment pulse whose seconds value differs from the alarm value leaves a clear flag clear.
- R6: Once set, the flag stays set across further increments and idle cycles until the alarm register is written.
- R7: Every write to the alarm register clears the flag, including a write of the value already held.
- R8: If a write and a matching increment fall in the same cycle, the write takes priority. The flag ends clear and the register holds the new data.
- R9: The interrupt output equals the flag ANDed with the enable input, both taken at the previous clock edge. The flag sets whether or not the enable is high.
- R10: After the alarm is loaded with a value below the current count (for example zero), increments with higher counts never set the flag.
- R11: The comparison uses only the seconds value present in the cycle of the increment pulse. An equal value in an earlier cycle without a pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_i | input | SEC_W | Current seconds count |
| tick_i | input | 1 | One-cycle pulse marking a seconds increment |
| alarm_wr_i | input | 1 | Alarm register write strobe |
| alarm_wdata_i | input | SEC_W | Data for the alarm register |
| irq_en_i | input | 1 | Interrupt enable |
| alarm_o | output | SEC_W | Alarm register readback |
| flag_o | output | 1 | Latched alarm flag |
| irq_o | output | 1 | Interrupt, flag gated by enable |

## Verification
The bench builds the block with its default width of 32 bits. Because it drives the seconds input directly instead of counting, it can present values far apart in consecutive cycles. That puts the all-ones boundary, a target of zero below a running count, and equal values that arrive without a pulse all within a few cycles. The same-cycle collision of a write and a matching increment is also exercised at this width.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned DEF_SEC_W = 32;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

  // A write beats a match; a match beats holding.
  function automatic flag_op_e pick_op(input logic wr, input logic hit);
    if (wr)       return FLAG_CLEAR;
    else if (hit) return FLAG_SET;
    else          return FLAG_HOLD;
  endfunction
endpackage

// File: rtl/rtc_alarm_store.sv
module rtc_alarm_store #(
  parameter int unsigned SEC_W = rtc_alarm_pkg::DEF_SEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [SEC_W-1:0] wdata_i,
  output logic [SEC_W-1:0] value_o
);
  logic [SEC_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst)       value_q <= '0;
    else if (wr_i) value_q <= wdata_i;
  end

  assign value_o = value_q;

  AST_WR_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (value_o == $past(wdata_i))); // R2
  AST_NO_WR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(value_o)); // R2
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned SEC_W = rtc_alarm_pkg::DEF_SEC_W
) (
  input  logic             tick_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] target_i,
  output logic             hit_o
);
  localparam int unsigned LANES = (SEC_W + 7) / 8;
  localparam int unsigned PAD_W = LANES * 8;

  logic [PAD_W-1:0] sec_pad, tgt_pad;
  logic [LANES-1:0] lane_eq;

  assign sec_pad = PAD_W'(sec_i);
  assign tgt_pad = PAD_W'(target_i);

  // Byte-wise equality, then a reduction across lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (sec_pad[g*8 +: 8] == tgt_pad[g*8 +: 8]);
  end

  assign hit_o = tick_i & (&lane_eq);
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
  import rtc_alarm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic hit_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  flag_op_e op;
  logic     flag_q, flag_d, irq_q;

  assign op = pick_op(wr_i, hit_i);

  always_comb begin
    unique case (op)
      FLAG_CLEAR: flag_d = 1'b0;
      FLAG_SET:   flag_d = 1'b1;
      default:    flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !flag_o); // R7
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !wr_i) |=> flag_o); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !hit_i) |=> !flag_o); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !wr_i) |=> flag_o); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_o); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o); // R9
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int unsigned SEC_W = rtc_alarm_pkg::DEF_SEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             tick_i,
  input  logic             alarm_wr_i,
  input  logic [SEC_W-1:0] alarm_wdata_i,
  input  logic             irq_en_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [SEC_W-1:0] target;
  logic             hit;

  rtc_alarm_store #(.SEC_W(SEC_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (alarm_wr_i),
    .wdata_i (alarm_wdata_i),
    .value_o (target)
  );

  rtc_alarm_match #(.SEC_W(SEC_W)) u_match (
    .tick_i   (tick_i),
    .sec_i    (sec_i),
    .target_i (target),
    .hit_o    (hit)
  );

  rtc_alarm_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (alarm_wr_i),
    .hit_i  (hit),
    .en_i   (irq_en_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  assign alarm_o = target;

  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !flag_o) |=> !flag_o); // R11
  AST_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (alarm_wr_i && tick_i && sec_i == alarm_o) |=> !flag_o); // R8
endmodule

// File: tb/test_rtc_alarm_unit.sv
`timescale 1ns/1ps
module test_rtc_alarm_unit;
  localparam int unsigned W = 32;

  typedef struct {
    logic         flag;
    logic         irq;
    logic [W-1:0] alarm;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sec = '0;
  logic         tick = 1'b0;
  logic         wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         en = 1'b0;
  logic [W-1:0] alarm_o;
  logic         flag_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb[$];

  logic         m_flag = 1'b0;
  logic [W-1:0] m_alarm = '0;

  always #2 clk = ~clk;

  rtc_alarm_unit #(.SEC_W(W)) i_rtc_alarm_unit (
    .clk(clk), .rst(rst), .sec_i(sec), .tick_i(tick),
    .alarm_wr_i(wr), .alarm_wdata_i(wdata), .irq_en_i(en),
    .alarm_o(alarm_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic step(input logic t, input logic [W-1:0] s, input logic w,
                      input logic [W-1:0] d, input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    tick = t; sec = s; wr = w; wdata = d; en = e;
    if (w)                         m_flag = 1'b0;
    else if (t && s == m_alarm)    m_flag = 1'b1;
    if (w) m_alarm = d;
    x.flag = m_flag; x.irq = m_flag & e; x.alarm = m_alarm; x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: after each rising edge, compare against the next expected item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        n_chk++;
        if (flag_o !== x.flag || irq_o !== x.irq || alarm_o !== x.alarm) begin
          n_bad++;
          $display("FAIL %s: got flag=%0b irq=%0b alarm=%h, expected flag=%0b irq=%0b alarm=%h",
                   x.tag, flag_o, irq_o, alarm_o, x.flag, x.irq, x.alarm);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (flag_o !== 1'b0 || irq_o !== 1'b0 || alarm_o !== '0) begin
      n_bad++;
      $display("FAIL R1: got flag=%0b irq=%0b alarm=%h, expected 0 0 0", flag_o, irq_o, alarm_o);
    end
    step(0, 32'd0,   1, 32'd100, 0, "R2 load");
    step(1, 32'd99,  0, 32'd0,   0, "R5 mismatch tick");
    step(0, 32'd100, 0, 32'd0,   0, "R4 equal without tick");
    step(1, 32'd100, 0, 32'd0,   0, "R3 match sets, R9 masked irq");
    step(0, 32'd100, 0, 32'd0,   1, "R9 enable raises irq");
    step(1, 32'd101, 0, 32'd0,   1, "R6 sticky over tick");
    step(0, 32'd101, 0, 32'd0,   0, "R9 enable low drops irq");
    step(0, 32'd101, 0, 32'd0,   1, "R6 sticky idle");
    step(0, 32'd101, 1, 32'd100, 1, "R7 rewrite same value clears");
    step(1, 32'd100, 0, 32'd0,   1, "R3 rearmed match");
    step(0, 32'd100, 1, 32'd0,   1, "R7 write zero clears");
    for (int k = 5; k < 9; k++)
      step(1, W'(k), 0, 32'd0, 1, "R10 below count stays disarmed");
    step(1, 32'd0,   1, 32'd200, 1, "R8 write beats matching tick");
    step(0, 32'd0,   1, 32'd50,  1, "R2 load 50");
    step(0, 32'd50,  0, 32'd0,   1, "R11 equal value no pulse");
    step(1, 32'd51,  0, 32'd0,   1, "R11 pulse with later value");
    step(1, 32'd50,  0, 32'd0,   1, "R11 pulse with equal value");
    step(0, 32'd50,  1, 32'hFFFF_FFFF, 1, "R7 load all ones");
    step(1, 32'hFFFF_FFFE, 0, 32'd0, 1, "R5 near boundary");
    step(1, 32'hFFFF_FFFF, 0, 32'd0, 1, "R3 all-ones match");
    step(0, 32'd0,   0, 32'd0,   1, "R6 idle after boundary");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    done = 1'b1;
    $finish;
  end
endmodule